// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous cache memory that serves four-word bursts. A start address and the chip-select state are loaded when either of two address strobes is active. The processor strobe is one; the controller strobe is the other. After that, an advance input steps the two low address bits through four beats. The upper address bits stay fixed while it does so. The step order is linear or interleaved. It is chosen by an order input, which is captured together with the address.

The control is a three-state machine. **ST_IDLE** means no selected burst; the flag is low and advance has no effect. **ST_LEAD** is the first beat of a burst, with beat count zero. **ST_STEP** covers the second to fourth beats.

The transitions are as follows. A load whose chip selects are true goes to ST_LEAD from any state. A load whose chip selects are false goes to ST_IDLE from any state. When there is no load, advance moves ST_LEAD to ST_STEP. Advance also moves ST_STEP to ST_STEP while the count is below three. Advance moves ST_STEP back to ST_LEAD when the count is three, which is the wrap. Without advance, the state holds.

The resulting access pattern is one load cycle followed by three single-cycle beats.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and `sel_out` is 0.
- R2: A processor strobe with `en_pri` high loads `addr_in` and the order input. The loaded address appears on `addr_out` after that clock edge. `sel_out` then equals `en_pri & en_hi & ~en_lo_n`.
- R3: A processor strobe while `en_pri` is low is ignored when the controller strobe is inactive. With advance low, `addr_out` and `sel_out` keep their values.
- R4: A controller strobe loads the address and chip-select state whatever the level of `en_pri`.
- R5: With linear order (captured `order_xor` = 0), beat n (0..3) outputs low bits (start + n) mod 4. Bits 16:2 equal those of the loaded address.
- R6: With interleaved order (captured `order_xor` = 1), beat n outputs low bits start XOR n. Bits 16:2 are unchanged.
- R7: With advance low and no accepted strobe, `addr_out` and `sel_out` hold, so wait states can be inserted.
- R8: Advancing from the fourth beat returns the low bits to the start value. There is no carry into bit 2.
- R9: An accepted strobe during a burst discards that burst and restarts at beat 0 from the new `addr_in`.
- R10: A load with the chip selects false drives `sel_out` low. Advance then leaves `addr_out` unchanged until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_proc | input | 1 | Processor address strobe, active high, honoured only with `en_pri` high |
| strobe_ctrl | input | 1 | Controller address strobe, active high |
| advance | input | 1 | Step to the next beat |
| order_xor | input | 1 | 1 = interleaved order, 0 = linear order, captured at load |
| addr_in | input | 17 | External start address |
| en_pri | input | 1 | Primary chip select, active high |
| en_hi | input | 1 | Expansion chip select, active high |
| en_lo_n | input | 1 | Expansion chip select, active low |
| addr_out | output | 17 | Current word address |
| sel_out | output | 1 | Burst active and chip selected |

## Verification
Both outputs come from registers. They show the effect of a strobe or an advance in the cycle right after the rising edge that samples it; no other register lies between. The bench drives inputs on the falling edge and checks both outputs one nanosecond after the following rising edge. Each expected value therefore matches exactly one sampled edge. The sweep covers both orders and all four start offsets, and for each one it advances through the wrap. It also inserts hold cycles between beats and interrupts bursts with reloads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    parameter int ADDR_W = 17;
    parameter int BEAT_W = 2;
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_STEP = 2'd2
    } seq_state_e;

    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] n,
        input logic              use_xor
    );
        if (use_xor) begin
            return start ^ n;
        end
        return start + n;
    endfunction
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb (
    input  logic strobe_proc,
    input  logic strobe_ctrl,
    input  logic en_pri,
    input  logic en_hi,
    input  logic en_lo_n,
    output logic load,
    output logic selected
);
    logic proc_ok;

    always_comb begin
        proc_ok  = strobe_proc & en_pri;
        load     = proc_ok | strobe_ctrl;
        selected = en_pri & en_hi & ~en_lo_n;
    end
endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             selected,
    input  logic             advance,
    output seq_state_e       state,
    output logic [CNT_W-1:0] beat,
    output logic             active
);
    localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

    seq_state_e       state_n;
    logic [CNT_W-1:0] beat_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_n;
            beat  <= beat_n;
        end
    end

    always_comb begin
        state_n = state;
        beat_n  = beat;
        if (load) begin
            state_n = selected ? ST_LEAD : ST_IDLE;
            beat_n  = '0;
        end else if (advance) begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_LEAD: begin
                    state_n = ST_STEP;
                    beat_n  = beat + 1'b1;
                end
                ST_STEP: begin
                    if (beat == LAST_BEAT) begin
                        state_n = ST_LEAD;
                        beat_n  = '0;
                    end else begin
                        beat_n  = beat + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    beat_n  = '0;
                end
            endcase
        end
    end

    always_comb begin
        active = (state != ST_IDLE);
    end

    // R8: advancing from the last beat returns to the lead beat
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && beat == LAST_BEAT && advance && !load)
        |=> (state == ST_LEAD && beat == '0));

    // R9: any accepted strobe restarts at beat 0
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat == '0));

    // R10: idle never advances
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load) |=> (state == ST_IDLE && $stable(beat)));
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_xor,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] addr_out
);
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  start_q;
    logic               xor_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
            xor_q   <= 1'b0;
        end else if (load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            xor_q   <= order_xor;
        end
    end

    always_comb begin
        addr_out = {upper_q, beat_low(start_q, beat, xor_q)};
    end

    // R5: upper bits never move without a load
    p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              en_pri,
    input  logic              en_hi,
    input  logic              en_lo_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel_out
);
    logic              load;
    logic              selected;
    seq_state_e        state;
    logic [BEAT_W-1:0] beat;

    burst_strobe_arb u_arb (
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .en_pri      (en_pri),
        .en_hi       (en_hi),
        .en_lo_n     (en_lo_n),
        .load        (load),
        .selected    (selected)
    );

    burst_seq_fsm #(.CNT_W(BEAT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .selected (selected),
        .advance  (advance),
        .state    (state),
        .beat     (beat),
        .active   (sel_out)
    );

    burst_addr_reg u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_in   (addr_in),
        .order_xor (order_xor),
        .beat      (beat),
        .addr_out  (addr_out)
    );

    // R3: a processor strobe without primary select is ignored
    p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc && !en_pri && !strobe_ctrl && !advance)
        |=> ($stable(addr_out) && $stable(sel_out)));

    // R7: no advance and no strobe holds the outputs
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !strobe_ctrl && !(strobe_proc && en_pri))
        |=> ($stable(addr_out) && $stable(sel_out)));

    // R4: a controller strobe always captures the address
    p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_ctrl |=> (addr_out == $past(addr_in)));
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
    import burst_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_proc = 1'b0;
    logic              strobe_ctrl = 1'b0;
    logic              advance = 1'b0;
    logic              order_xor = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              en_pri = 1'b0;
    logic              en_hi = 1'b0;
    logic              en_lo_n = 1'b1;
    logic [ADDR_W-1:0] addr_out;
    logic              sel_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_proc (strobe_proc),
        .strobe_ctrl (strobe_ctrl),
        .advance     (advance),
        .order_xor   (order_xor),
        .addr_in     (addr_in),
        .en_pri      (en_pri),
        .en_hi       (en_hi),
        .en_lo_n     (en_lo_n),
        .addr_out    (addr_out),
        .sel_out     (sel_out)
    );

    task automatic step(input logic p, input logic c, input logic a, input logic m,
                        input logic [ADDR_W-1:0] ad, input logic e0, input logic e1,
                        input logic e2n);
        @(negedge clk);
        strobe_proc = p;
        strobe_ctrl = c;
        advance     = a;
        order_xor   = m;
        addr_in     = ad;
        en_pri      = e0;
        en_hi       = e1;
        en_lo_n     = e2n;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [ADDR_W-1:0] exp_a, input logic exp_s);
        checks++;
        if (addr_out !== exp_a || sel_out !== exp_s) begin
            errors++;
            $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b",
                     req, addr_out, sel_out, exp_a, exp_s);
        end
    endtask

    function automatic logic [ADDR_W-1:0] expect_addr(input logic [ADDR_W-1:0] base,
                                                       input int n, input logic m);
        int lo;
        lo = m ? (int'(base[1:0]) ^ n) : ((int'(base[1:0]) + n) % 4);
        return {base[ADDR_W-1:2], 2'(lo)};
    endfunction

    initial begin
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
        #10;
        chk("R1", '0, 1'b0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 17'h1ffff, 1, 1, 0);
        chk("R1", '0, 1'b0);
        // R10 advance in idle has no effect
        step(0, 0, 1, 0, '0, 1, 1, 0);
        chk("R10", '0, 1'b0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                base = {15'(17'h0A5C3 + s * 977 + m * 31), 2'(s)};
                if (s[0]) step(1, 0, 0, m[0], base, 1, 1, 0);
                else      step(0, 1, 0, m[0], base, 1, 1, 0);
                chk(s[0] ? "R2" : "R4", base, 1'b1);
                for (int n = 1; n <= 5; n++) begin
                    // change order input mid-burst: must not matter (captured)
                    step(0, 0, 1, ~m[0], 17'h0, 1, 1, 0);
                    chk(m ? "R6" : "R5", expect_addr(base, n % 4, m[0]), 1'b1);
                    if (n == 4) chk("R8", base, 1'b1);
                    if (n == 2) begin
                        step(0, 0, 0, m[0], 17'h1, 1, 1, 0);
                        chk("R7", expect_addr(base, 2, m[0]), 1'b1);
                    end
                end
                // now at beat 1; ignored processor strobe
                cur = expect_addr(base, 1, m[0]);
                step(1, 0, 0, m[0], 17'h15555, 0, 1, 0);
                chk("R3", cur, 1'b1);
                // reload mid-burst
                step(1, 0, 0, m[0], base ^ 17'h00003, 1, 1, 0);
                chk("R9", base ^ 17'h00003, 1'b1);
                step(0, 0, 1, m[0], '0, 1, 1, 0);
                chk("R9", expect_addr(base ^ 17'h00003, 1, m[0]), 1'b1);
            end
        end

        // R4 controller strobe with primary select low loads, deselected
        step(0, 1, 0, 0, 17'h0ABCD, 0, 1, 0);
        chk("R4", 17'h0ABCD, 1'b0);
        step(0, 0, 1, 0, '0, 0, 1, 0);
        chk("R10", 17'h0ABCD, 1'b0);
        // R10 deselect through expansion selects
        step(1, 0, 0, 1, 17'h12346, 1, 1, 1);
        chk("R10", 17'h12346, 1'b0);
        step(0, 0, 1, 1, '0, 1, 1, 0);
        chk("R10", 17'h12346, 1'b0);
        step(0, 1, 0, 1, 17'h00002, 1, 0, 0);
        chk("R10", 17'h00002, 1'b0);
        step(0, 0, 1, 1, '0, 1, 1, 0);
        chk("R10", 17'h00002, 1'b0);
        // R8 no carry into bit 2 from an all-ones start
        step(0, 1, 0, 0, 17'h0FFFF, 1, 1, 0);
        chk("R8", 17'h0FFFF, 1'b1);
        step(0, 0, 1, 0, '0, 1, 1, 0);
        chk("R8", 17'h0FFFC, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule